// File: doc/BRIEF.md
# General-Purpose I/O Port with Direction Control

This block is an 8-bit memory-mapped I/O port for a small microcontroller core. Six of its bits reach pads. It holds an output data latch, which the port-write strobe loads, and a direction register, which only a separate direction-load strobe loads, taking its value from the accumulator. Per-pin output-enable and output-data signals go to the pad cells. A port read returns the live pin levels, not the latch contents.

Static configuration inputs change how some pins behave. Any pin can be given to an alternate function. Pin 2 can be given to a timer clock input. Pin 3 can act as the reset input. A global weak pull-up enable and a global wake-on-change enable act on pins 0, 1 and 3. Every port read takes a snapshot of the pins. A wake request is raised while an enabled pin differs from that snapshot.

Top module: `gpio_port_top`

## Requirements
- R1: While rst_ni is low, every direction bit is 1, the output latch is 0 and the wake snapshot is 0, so pad_oe_o and pad_do_o are all 0.
- R2: When port_wr_i is high at a clock edge, the latch loads port_wd_i[5:0] and pad_do_o shows it after that edge. Bits 7:6 are ignored. The latch holds its value until the next port write.
- R3: When dir_wr_i is high at a clock edge, the direction register loads acc_i[5:0]. A 0 bit enables that pin's driver and a 1 bit puts the pin in high impedance. A port write never changes the direction register.
- R4: rdata_o[5:0] shows the current pin_i levels, not the latch, and rdata_o[7:6] is always 0.
- R5: Pin 3 is input only. pad_oe_o[3] and pad_do_o[3] are always 0, whatever the direction register holds.
- R6: A pin with alt_sel_i set reads as 0 in rdata_o.
- R7: While tmr_sel_i is high, pin 2 has pad_oe_o[2]=0 and pad_do_o[2]=0, and it reads as 0.
- R8: pu_o[0] and pu_o[1] follow pu_en_i. pu_o[3] also follows pu_en_i unless R9 applies. pu_o[2], pu_o[4] and pu_o[5] are always 0.
- R9: While rst_pin_sel_i is high, pu_o[3] is 1, pin 3 is left out of the wake compare, and pin 3 reads as 0.
- R10: At each clock edge where port_rd_i is high, the snapshot captures pin_i. wake_o is high exactly when wake_en_i is high and any pin 0, 1 or 3 (pin 3 only when R9 does not apply) differs from its snapshot bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_wr_i | input | 1 | Port write strobe |
| port_wd_i | input | 8 | Port write data |
| dir_wr_i | input | 1 | Direction load strobe |
| acc_i | input | 8 | Accumulator value for the direction load |
| port_rd_i | input | 1 | Port read strobe; takes the wake snapshot |
| pin_i | input | 6 | Pin levels from the pads |
| alt_sel_i | input | 6 | Per-pin alternate-function select |
| tmr_sel_i | input | 1 | Gives pin 2 to the timer clock input |
| rst_pin_sel_i | input | 1 | Pin 3 acts as the reset input |
| pu_en_i | input | 1 | Global weak pull-up enable |
| wake_en_i | input | 1 | Global wake-on-change enable |
| rdata_o | output | 8 | Port read data |
| pad_oe_o | output | 6 | Per-pin output enable |
| pad_do_o | output | 6 | Per-pin output data |
| pu_o | output | 6 | Per-pin weak pull-up enable |
| wake_o | output | 1 | Wake request |

## Verification
The direction register cannot be read back. A wrong direction bit therefore shows only on pad_oe_o, and it shows one cycle after the load. If the latch is wrong, pad_do_o is wrong on every following cycle until the next port write. If the snapshot is wrong, wake_o goes wrong as soon as wake_en_i is high, and it stays wrong until the next port read, so the bench compares every output against a model on every cycle. Holding a pin low under a driven 1 separates a read of the pin from a read of the latch.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int PORT_W      = 8;
  localparam int PIN_N       = 6;
  localparam int IN_ONLY_IDX = 3;
  localparam int TMR_IDX     = 2;
  localparam int RST_IDX     = 3;
  localparam int WK_A_IDX    = 0;
  localparam int WK_B_IDX    = 1;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PIN_N = gpio_port_pkg::PIN_N
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             port_wr_i,
  input  logic [PIN_N-1:0] port_wd_i,
  input  logic             dir_wr_i,
  input  logic [PIN_N-1:0] acc_i,
  output logic [PIN_N-1:0] latch_o,
  output logic [PIN_N-1:0] dir_o
);
  logic [PIN_N-1:0] latch_q, dir_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        latch_q <= '0;
    else if (port_wr_i) latch_q <= port_wd_i;
  end

  // direction resets to all inputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       dir_q <= '1;
    else if (dir_wr_i) dir_q <= acc_i;
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;

  AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !port_wr_i |=> $stable(latch_q)); // R2
  AST_DIR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr_i |=> dir_q == $past(acc_i)); // R3
  AST_DIR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dir_wr_i |=> $stable(dir_q)); // R3
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int PIN_N       = gpio_port_pkg::PIN_N,
  parameter int IN_ONLY_IDX = gpio_port_pkg::IN_ONLY_IDX,
  parameter int TMR_IDX     = gpio_port_pkg::TMR_IDX
) (
  input  logic [PIN_N-1:0] latch_i,
  input  logic [PIN_N-1:0] dir_i,
  input  logic             tmr_sel_i,
  output logic [PIN_N-1:0] oe_o,
  output logic [PIN_N-1:0] do_o
);
  for (genvar i = 0; i < PIN_N; i++) begin : g_pin
    if (i == IN_ONLY_IDX) begin : g_in_only
      assign oe_o[i] = 1'b0;
      assign do_o[i] = 1'b0;
    end else if (i == TMR_IDX) begin : g_tmr
      assign oe_o[i] = ~dir_i[i] & ~tmr_sel_i;
      assign do_o[i] = latch_i[i] & ~tmr_sel_i;
    end else begin : g_plain
      assign oe_o[i] = ~dir_i[i];
      assign do_o[i] = latch_i[i];
    end
  end
endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path #(
  parameter int PORT_W  = gpio_port_pkg::PORT_W,
  parameter int PIN_N   = gpio_port_pkg::PIN_N,
  parameter int TMR_IDX = gpio_port_pkg::TMR_IDX,
  parameter int RST_IDX = gpio_port_pkg::RST_IDX
) (
  input  logic [PIN_N-1:0]  pin_i,
  input  logic [PIN_N-1:0]  alt_i,
  input  logic              tmr_sel_i,
  input  logic              rst_sel_i,
  output logic [PORT_W-1:0] rdata_o
);
  localparam int PAD_W = PORT_W - PIN_N;
  logic [PIN_N-1:0] hide;

  always_comb begin
    hide          = alt_i;
    hide[TMR_IDX] = alt_i[TMR_IDX] | tmr_sel_i;
    hide[RST_IDX] = alt_i[RST_IDX] | rst_sel_i;
  end

  // pins are read live, never the latch
  assign rdata_o = {{PAD_W{1'b0}}, pin_i & ~hide};
endmodule

// File: rtl/gpio_wake.sv
module gpio_wake #(
  parameter int PIN_N    = gpio_port_pkg::PIN_N,
  parameter int WK_A_IDX = gpio_port_pkg::WK_A_IDX,
  parameter int WK_B_IDX = gpio_port_pkg::WK_B_IDX,
  parameter int RST_IDX  = gpio_port_pkg::RST_IDX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_i,
  input  logic [PIN_N-1:0] pin_i,
  input  logic             pu_en_i,
  input  logic             wake_en_i,
  input  logic             rst_sel_i,
  output logic [PIN_N-1:0] pu_o,
  output logic             wake_o
);
  logic [PIN_N-1:0] snap_q, wmask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   snap_q <= '0;
    else if (rd_i) snap_q <= pin_i;
  end

  always_comb begin
    wmask           = '0;
    wmask[WK_A_IDX] = 1'b1;
    wmask[WK_B_IDX] = 1'b1;
    wmask[RST_IDX]  = ~rst_sel_i;
    pu_o            = '0;
    pu_o[WK_A_IDX]  = pu_en_i;
    pu_o[WK_B_IDX]  = pu_en_i;
    pu_o[RST_IDX]   = pu_en_i | rst_sel_i;
  end

  assign wake_o = wake_en_i & |((pin_i ^ snap_q) & wmask);

  AST_SNAP_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> snap_q == $past(pin_i)); // R10
  AST_SNAP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> $stable(snap_q)); // R10
  AST_WAKE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wake_en_i |-> !wake_o); // R10
  AST_RST_PULLUP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_sel_i |-> pu_o[RST_IDX]); // R9
endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top #(
  parameter int PORT_W = gpio_port_pkg::PORT_W,
  parameter int PIN_N  = gpio_port_pkg::PIN_N
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              port_wr_i,
  input  logic [PORT_W-1:0] port_wd_i,
  input  logic              dir_wr_i,
  input  logic [PORT_W-1:0] acc_i,
  input  logic              port_rd_i,
  input  logic [PIN_N-1:0]  pin_i,
  input  logic [PIN_N-1:0]  alt_sel_i,
  input  logic              tmr_sel_i,
  input  logic              rst_pin_sel_i,
  input  logic              pu_en_i,
  input  logic              wake_en_i,
  output logic [PORT_W-1:0] rdata_o,
  output logic [PIN_N-1:0]  pad_oe_o,
  output logic [PIN_N-1:0]  pad_do_o,
  output logic [PIN_N-1:0]  pu_o,
  output logic              wake_o
);
  import gpio_port_pkg::*;

  logic [PIN_N-1:0] latch, dir;
  logic             unused_hi;

  assign unused_hi = ^{port_wd_i[PORT_W-1:PIN_N], acc_i[PORT_W-1:PIN_N]};

  gpio_port_regs #(.PIN_N(PIN_N)) u_regs (
    .clk_i, .rst_ni, .port_wr_i,
    .port_wd_i(port_wd_i[PIN_N-1:0]),
    .dir_wr_i,
    .acc_i    (acc_i[PIN_N-1:0]),
    .latch_o  (latch),
    .dir_o    (dir)
  );

  gpio_pad_ctl #(.PIN_N(PIN_N), .IN_ONLY_IDX(IN_ONLY_IDX), .TMR_IDX(TMR_IDX)) u_pad (
    .latch_i  (latch),
    .dir_i    (dir),
    .tmr_sel_i,
    .oe_o     (pad_oe_o),
    .do_o     (pad_do_o)
  );

  gpio_rd_path #(.PORT_W(PORT_W), .PIN_N(PIN_N), .TMR_IDX(TMR_IDX), .RST_IDX(RST_IDX)) u_rd (
    .pin_i,
    .alt_i    (alt_sel_i),
    .tmr_sel_i,
    .rst_sel_i(rst_pin_sel_i),
    .rdata_o
  );

  gpio_wake #(.PIN_N(PIN_N), .WK_A_IDX(WK_A_IDX), .WK_B_IDX(WK_B_IDX), .RST_IDX(RST_IDX)) u_wake (
    .clk_i, .rst_ni,
    .rd_i     (port_rd_i),
    .pin_i,
    .pu_en_i,
    .wake_en_i,
    .rst_sel_i(rst_pin_sel_i),
    .pu_o,
    .wake_o
  );

  AST_IN_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pad_oe_o[IN_ONLY_IDX]); // R5
  AST_TMR_HIZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_sel_i |-> !pad_oe_o[TMR_IDX] && !rdata_o[TMR_IDX]); // R7
  AST_DIR_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr_i && acc_i[0] |=> !pad_oe_o[0]); // R3
  AST_ALT_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alt_sel_i[0] |-> !rdata_o[0]); // R6
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_top_tb_top;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic port_wr, dir_wr, port_rd, tmr_sel, rst_sel, pu_en, wake_en;
  logic [7:0] port_wd, acc, rdata;
  logic [5:0] pin, alt_sel, pad_oe, pad_do, pu;
  logic wake;
  int total = 0, bad = 0;
  logic done = 1'b0;
  logic [5:0] m_latch, m_dir, m_snap;

  always #2 clk = ~clk;

  gpio_port_top dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .port_wr_i(port_wr), .port_wd_i(port_wd),
    .dir_wr_i(dir_wr), .acc_i(acc), .port_rd_i(port_rd), .pin_i(pin),
    .alt_sel_i(alt_sel), .tmr_sel_i(tmr_sel), .rst_pin_sel_i(rst_sel),
    .pu_en_i(pu_en), .wake_en_i(wake_en), .rdata_o(rdata), .pad_oe_o(pad_oe),
    .pad_do_o(pad_do), .pu_o(pu), .wake_o(wake)
  );

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] e_rd();
    logic [5:0] v = pin & ~alt_sel;
    if (tmr_sel) v[2] = 1'b0;
    if (rst_sel) v[3] = 1'b0;
    return {2'b00, v};
  endfunction
  function automatic logic [5:0] e_oe();
    logic [5:0] v = ~m_dir;
    v[3] = 1'b0;
    if (tmr_sel) v[2] = 1'b0;
    return v;
  endfunction
  function automatic logic [5:0] e_do();
    logic [5:0] v = m_latch;
    v[3] = 1'b0;
    if (tmr_sel) v[2] = 1'b0;
    return v;
  endfunction
  function automatic logic [5:0] e_pu();
    return {2'b00, pu_en | rst_sel, 1'b0, pu_en, pu_en};
  endfunction
  function automatic logic e_wake();
    logic [5:0] m = {2'b00, ~rst_sel, 1'b0, 2'b11};
    return wake_en & |((pin ^ m_snap) & m);
  endfunction

  task automatic check_all();
    check("R4/R6/R7/R9 rdata", rdata, e_rd());
    check("R3/R5/R7 pad_oe", {2'b00, pad_oe}, {2'b00, e_oe()});
    check("R2/R5/R7 pad_do", {2'b00, pad_do}, {2'b00, e_do()});
    check("R8/R9 pu", {2'b00, pu}, {2'b00, e_pu()});
    check("R10 wake", {7'd0, wake}, {7'd0, e_wake()});
  endtask

  task automatic step();
    #1;
    check_all();
    @(posedge clk);
    if (port_wr) m_latch = port_wd[5:0];
    if (dir_wr)  m_dir   = acc[5:0];
    if (port_rd) m_snap  = pin;
    @(negedge clk);
    port_wr = 1'b0; dir_wr = 1'b0; port_rd = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    port_wr = 0; dir_wr = 0; port_rd = 0; tmr_sel = 0; rst_sel = 0;
    pu_en = 0; wake_en = 0; port_wd = 0; acc = 0; pin = 6'h3f; alt_sel = 0;
    m_latch = 6'h00; m_dir = 6'h3f; m_snap = 6'h00;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 pad_oe", {2'b00, pad_oe}, 8'h00);
    check("R1 pad_do", {2'b00, pad_do}, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk);
    // R2: write all ones; bits 7:6 ignored, drivers still off (R3 reset)
    port_wr = 1; port_wd = 8'hff; step();
    step();
    // R3: enable all drivers
    dir_wr = 1; acc = 8'h00; step();
    step();
    // R4: pins held low under driven ones read 0
    pin = 6'h00; step();
    check("R4 held low", rdata, 8'h00);
    // R3: port write leaves direction alone
    port_wr = 1; port_wd = 8'h2a; acc = 8'h3f; step();
    step();
    // R5: pin 3 stays off with its direction bit cleared
    dir_wr = 1; acc = 8'h00; step();
    check("R5 pin3 oe", {7'd0, pad_oe[3]}, 8'h00);
    // R7 timer takeover, R6 alternate, R9 reset pin
    pin = 6'h3f; tmr_sel = 1; alt_sel = 6'h21; rst_sel = 1; pu_en = 0; step();
    check("R9 pu3", {7'd0, pu[3]}, 8'h01);
    tmr_sel = 0; alt_sel = 0; rst_sel = 0; pu_en = 1; step();
    // R10: snapshot and wake
    wake_en = 1; pin = 6'h00; port_rd = 1; step();
    pin = 6'h01; step();
    check("R10 wake on change", {7'd0, wake}, 8'h01);
    port_rd = 1; step();
    step();
    pin = 6'h09; rst_sel = 1; step();
    check("R9 pin3 excluded", {7'd0, wake}, 8'h00);
    pin = 6'h31; rst_sel = 0; step();
    check("R10 pins 4,5 ignored", {7'd0, wake}, 8'h00);
    // random
    for (int i = 0; i < 600; i++) begin
      port_wr = ($urandom % 4) == 0;
      dir_wr  = ($urandom % 5) == 0;
      port_rd = ($urandom % 4) == 0;
      port_wd = 8'($urandom);
      acc     = 8'($urandom);
      pin     = 6'($urandom);
      alt_sel = (($urandom % 3) == 0) ? 6'($urandom) : 6'h00;
      tmr_sel = ($urandom % 4) == 0;
      rst_sel = ($urandom % 4) == 0;
      pu_en   = 1'($urandom);
      wake_en = 1'($urandom);
      step();
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule